// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block limits the peak current of an H-bridge by cutting the drive short whenever the current gets too high. While the external PWM enable is high, a digital comparator flag reports that the sensed current has passed the reference. A blanking window comes first, and the flag is not looked at during it. Once that window has passed, the first flag ends the on-time. The block then holds the bridge in a decay off-time of fixed length. The first part of the off-time is fast decay and the rest is slow decay. After the off-time, a new drive cycle starts with a fresh blanking window.

The chop-active and decay-select outputs go to the bridge decoder, which turns them into gate states. During fast decay, a zero-current flag from the sense path raises a high-impedance request, so the bridge stops driving once the load current has collapsed. A control-enable input turns the whole feature off. All time constants are clock-cycle counts. The fast-decay length is an integer fraction of the off-time.

Top module: `chop_offtime`

## Requirements
- R1: While reset is asserted, and directly after it, chop_o, fast_o and hiz_o are all 0.
- R2: If trip_i and ctl_en_i are high at a clock edge where drive is on and the blanking window has expired, chop_o is 1 from that edge on for exactly OFF_CYC cycles. It then returns to 0.
- R3: During an off-time, fast_o is 1 for the first FAST_CYC cycles, where FAST_CYC = floor(OFF_CYC*FAST_NUM/FAST_DEN). It is 0 for the remaining cycles (slow decay). fast_o is never 1 outside an off-time.
- R4: The blanking window is BLANK_CYC cycles. Take the first edge that samples drive_en_i high after it was low. If trip_i is held high from then on, the earliest edge that can start an off-time is BLANK_CYC+1 edges later. A trip pulse inside the window is ignored.
- R5: The blanking window restarts at the end of every off-time. With trip_i held high, chop_o stays 0 for exactly BLANK_CYC+1 cycles between two off-times.
- R6: While ctl_en_i is low, no off-time starts. If ctl_en_i is sampled low during an off-time, chop_o drops at that edge and a fresh blanking window begins.
- R7: An edge that samples drive_en_i low sends the block to idle. chop_o and fast_o are 0 from that edge on, and a running off-time is abandoned. When drive returns, R4 applies again.
- R8: hiz_o equals fast_o AND zero_i, with no added cycle of delay. It is 0 whenever fast_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drive_en_i | input | 1 | External PWM drive enable |
| trip_i | input | 1 | Sense current above reference |
| ctl_en_i | input | 1 | Current-control feature enable |
| zero_i | input | 1 | Load current near zero |
| chop_o | output | 1 | Off-time in progress |
| fast_o | output | 1 | Decay select: 1 fast, 0 slow |
| hiz_o | output | 1 | Request to release the bridge outputs |

## Verification
A steady trip with drive on produces a train of off-times. This pattern fixes the position of the first off-time after the blanking window, the off-time length, the fast-to-slow split and the gap between off-times, and toggling zero_i during it separates hiz_o from fast_o. Single trip pulses, one inside the blanking window and one after it, show the difference between an ignored flag and an accepted one. Dropping the control enable or the drive enable partway through an off-time shows the two abort paths: the first goes straight to a fresh blanking window, the second goes through idle and a new rising edge.

// File: rtl/chop_pkg.sv
package chop_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BLANK = 2'd1,
      ST_ARMED = 2'd2,
      ST_OFF   = 2'd3
   } chop_st_e;
endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
   parameter int CW  = 6,
   parameter int MAX = 40
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   output logic [CW-1:0] cnt_o
);
   localparam logic [CW-1:0] CNT_MAX = CW'(MAX);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr_i)          cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R2: the counter saturates and never runs past its limit
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);

   // R5: a clear always restarts the count from zero
   p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
   import chop_pkg::*;
#(
   parameter int CW        = 6,
   parameter int BLANK_CYC = 8,
   parameter int OFF_CYC   = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          drive_en_i,
   input  logic          trip_i,
   input  logic          ctl_en_i,
   input  logic [CW-1:0] cnt_i,
   output logic          clr_o,
   output logic          in_off_o
);
   localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_CYC - 1);
   localparam logic [CW-1:0] OFF_LAST   = CW'(OFF_CYC - 1);

   chop_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (!drive_en_i) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE:  st_d = ST_BLANK;
            ST_BLANK: if (cnt_i == BLANK_LAST) st_d = ST_ARMED;
            ST_ARMED: if (ctl_en_i && trip_i) st_d = ST_OFF;
            ST_OFF:   if (!ctl_en_i || cnt_i == OFF_LAST) st_d = ST_BLANK;
            default:  st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign clr_o    = (st_d != st_q);
   assign in_off_o = (st_q == ST_OFF);

   // R7: a low drive enable always lands the machine in idle
   p_drive_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_en_i |=> (st_q == ST_IDLE));

   // R6: with control disabled no off-time can begin
   p_ctl_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_en_i && st_q != ST_OFF) |=> (st_q != ST_OFF));

   // R2: every off-time entry is caused by an accepted trip
   p_trip_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_OFF && $past(st_q) != ST_OFF) |-> ($past(trip_i) && $past(ctl_en_i)));

   // R4: an off-time is never entered straight from blanking
   p_blank_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BLANK) |=> (st_q != ST_OFF));
endmodule

// File: rtl/chop_decay.sv
module chop_decay #(
   parameter int CW       = 6,
   parameter int FAST_CYC = 5,
   parameter bit HIZ_EN   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_off_i,
   input  logic [CW-1:0] cnt_i,
   input  logic          zero_i,
   output logic          fast_o,
   output logic          hiz_o
);
   generate
      if (FAST_CYC == 0) begin : g_slow_only
         assign fast_o = 1'b0;
      end else begin : g_mixed
         localparam logic [CW-1:0] FAST_LIM = CW'(FAST_CYC);
         assign fast_o = in_off_i && (cnt_i < FAST_LIM);
      end

      if (HIZ_EN) begin : g_hiz
         assign hiz_o = fast_o && zero_i;
      end else begin : g_no_hiz
         assign hiz_o = 1'b0;
      end
   endgenerate

   // R3: once slow decay starts, fast decay does not return within the off-time
   p_fast_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_off_i && !fast_o) |=> !fast_o);

   // R3: fast decay only inside an off-time
   p_fast_in_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fast_o |-> in_off_i);
endmodule

// File: rtl/chop_offtime.sv
module chop_offtime #(
   parameter int BLANK_CYC = 8,
   parameter int OFF_CYC   = 32,
   parameter int FAST_NUM  = 18,
   parameter int FAST_DEN  = 100,
   parameter bit HIZ_EN    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic drive_en_i,
   input  logic trip_i,
   input  logic ctl_en_i,
   input  logic zero_i,
   output logic chop_o,
   output logic fast_o,
   output logic hiz_o
);
   localparam int FAST_CYC = (OFF_CYC * FAST_NUM) / FAST_DEN;
   localparam int CNT_MAX  = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
   localparam int CW       = $clog2(CNT_MAX + 1);

   generate
      if (BLANK_CYC < 1) begin : g_bad_blank
         $error("BLANK_CYC must be at least 1");
      end
      if (OFF_CYC < 2) begin : g_bad_off
         $error("OFF_CYC must be at least 2");
      end
      if (FAST_DEN < 1 || FAST_NUM < 0 || FAST_NUM > FAST_DEN) begin : g_bad_frac
         $error("fast-decay fraction must lie in [0,1]");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          clr;
   logic          in_off;

   chop_timer #(.CW(CW), .MAX(CNT_MAX)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr),
      .cnt_o (cnt)
   );

   chop_fsm #(.CW(CW), .BLANK_CYC(BLANK_CYC), .OFF_CYC(OFF_CYC)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .drive_en_i (drive_en_i),
      .trip_i     (trip_i),
      .ctl_en_i   (ctl_en_i),
      .cnt_i      (cnt),
      .clr_o      (clr),
      .in_off_o   (in_off)
   );

   chop_decay #(.CW(CW), .FAST_CYC(FAST_CYC), .HIZ_EN(HIZ_EN)) u_decay (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_off_i (in_off),
      .cnt_i    (cnt),
      .zero_i   (zero_i),
      .fast_o   (fast_o),
      .hiz_o    (hiz_o)
   );

   assign chop_o = in_off;

   generate
      if (FAST_CYC > 0) begin : g_first_fast
         // R3: every off-time opens in fast decay
         p_first_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(chop_o) |-> fast_o);
      end
   endgenerate

   // R7: a dropped drive enable clears chopping on the next edge
   p_no_chop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_en_i |=> !chop_o);
endmodule

// File: tb/chop_offtime_tb.sv
module chop_offtime_tb;
   localparam int CLK_PERIOD = 10;
   localparam int B    = 8;
   localparam int OFF  = 32;
   localparam int FAST = (OFF * 18) / 100;
   localparam int P    = OFF + B + 1;

   typedef struct {
      bit    c;
      bit    f;
      bit    h;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic drive_en = 1'b0, trip = 1'b0, ctl_en = 1'b1, zero = 1'b0;
   logic chop, fast, hiz;

   int checks = 0;
   int errors = 0;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   chop_offtime #(.BLANK_CYC(B), .OFF_CYC(OFF), .FAST_NUM(18), .FAST_DEN(100)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .drive_en_i (drive_en),
      .trip_i     (trip),
      .ctl_en_i   (ctl_en),
      .zero_i     (zero),
      .chop_o     (chop),
      .fast_o     (fast),
      .hiz_o      (hiz)
   );

   // monitor: compares outputs shortly after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (chop !== e.c || fast !== e.f || hiz !== e.h) begin
               errors++;
               $display("FAIL %s at %0t: actual chop=%b fast=%b hiz=%b expected chop=%b fast=%b hiz=%b",
                        e.tag, $time, chop, fast, hiz, e.c, e.f, e.h);
            end
         end
      end
   end

   task automatic step(input bit d, input bit t, input bit c, input bit z,
                       input bit ec, input bit ef, input string tag);
      exp_t e;
      @(negedge clk);
      drive_en = d; trip = t; ctl_en = c; zero = z;
      e.c = ec; e.f = ef; e.h = ef & z; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 idle");
   endtask

   // expected off-time train with the first off-time starting at edge 'first'
   function automatic void train(input int k, input int first, output bit c, output bit f);
      int m;
      m = k - first;
      c = (m >= 0) && ((m % P) < OFF);
      f = (m >= 0) && ((m % P) < FAST);
   endfunction

   initial begin
      bit c, f;
      int k5;
      // R1: outputs during reset
      #(CLK_PERIOD*2 + 3);
      checks++;
      if (chop !== 1'b0 || fast !== 1'b0 || hiz !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: actual %b%b%b expected 000", chop, fast, hiz);
      end
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // steady trip: R2 R3 R4 R5 R8
      for (int k = 1; k <= B + 2 + 2*P + 6; k++) begin
         train(k, B + 2, c, f);
         step(1'b1, 1'b1, 1'b1, bit'((k / 2) % 2), c, f, "R2 R3 R4 R5 R8 train");
      end

      // trip pulses: inside blank ignored (R4), after blank accepted (R2)
      idle(2);
      for (int k = 1; k <= B + 5 + OFF + B + 4; k++) begin
         c = (k >= B + 5) && (k < B + 5 + OFF);
         f = (k >= B + 5) && (k < B + 5 + FAST);
         step(1'b1, bit'(k == 3 || k == B + 5), 1'b1, 1'b1, c, f, "R4 R2 pulse");
      end

      // control disabled: R6
      idle(2);
      for (int k = 1; k <= 2*P; k++) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 disabled");

      // control dropped inside an off-time: R6
      idle(2);
      k5 = B + 2 + 3;
      for (int k = 1; k < k5; k++) begin
         train(k, B + 2, c, f);
         step(1'b1, 1'b1, 1'b1, 1'b0, c, f, "R6 pre-drop");
      end
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 drop");
      for (int k = k5 + 1; k <= k5 + B + 1 + OFF + 2; k++) begin
         train(k, k5 + B + 1, c, f);
         step(1'b1, 1'b1, 1'b1, 1'b0, c, f, "R6 R5 restart");
      end

      // drive dropped inside an off-time: R7
      idle(2);
      for (int k = 1; k < k5; k++) begin
         train(k, B + 2, c, f);
         step(1'b1, 1'b1, 1'b1, 1'b1, c, f, "R7 pre-drop");
      end
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7 drop");
      for (int k = k5 + 1; k <= k5 + B + 2 + OFF + 2; k++) begin
         train(k, k5 + B + 2, c, f);
         step(1'b1, 1'b1, 1'b1, 1'b1, c, f, "R7 R4 restart");
      end

      idle(3);
      repeat (2) @(posedge clk);
      #5;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule